// File: doc/BRIEF.md
# Strap Latch and Frequency-Select Controller

This block decides which frequency code the clock synthesizer runs from. Four of the chip's clock output pins also act as configuration straps. While the supply is coming up, their drivers stay off and the block reads the pins as inputs. After power-good has been high for a set number of reference-clock cycles, the block freezes the strap values and turns the pin drivers on. From then on, those pins carry clocks.

The active 5-bit code comes from one of two sources:
- the frozen straps, with the top bit forced to 0;
- software bits in control register 0, when that register's override bit is set.

The block sorts every code into one of three PLL groups. Whenever the code changes, it raises a one-cycle pulse, together with a flag that tells the PLL whether the move can be made without a glitch (same group) or must be an immediate jump (different group). A separate register bit lets software supply the PLL's N and R divider values directly, and the block forwards those values.

Top module: `freq_sel_ctrl`

## Requirements
- R1: `pin_oe` is 0 from reset. It becomes 1 exactly `SETTLE_CYCLES` rising clock edges after `pwr_good` is first seen high, and then stays 1 until reset. If `pwr_good` drops before that point, the count restarts.
- R2: The strap pins pass through a two-flop synchronizer. The value latched is the synchronized value at the moment `pin_oe` rises. Later changes on `strap_pin` have no effect on `code`.
- R3: When `reg0[3]` is 0, `code` is {1'b0, S3, S2, S1, S0}, where `strap_pin[3]`=S3, `strap_pin[2]`=S2, `strap_pin[1]`=S1 and `strap_pin[0]`=S0.
- R4: When `reg0[3]` is 1, `code` is {reg0[7], reg0[2], reg0[6], reg0[5], reg0[4]}, listed from code bit 4 down to bit 0.
- R5: `group` classifies `code` as follows:
  - 2'd1 for 00001, 00010, 00111, 01101, 10001, 10010, 10111, 11010, 11011, 11100, 11101, 11110 and 11111;
  - 2'd2 for 00000, 00011, 00110, 01010, 10000 and 10101;
  - 2'd3 for every other code.
- R6: When the resolved code changes, `code` takes the new value on the next clock edge. `code_change` is 1 for exactly that one cycle.
- R7: At each change, `smooth` is set to 1 if the old and new codes are in the same group and to 0 otherwise. It holds that value until the next change.
- R8: When `reg8[0]` is 1, the outputs are registered one cycle after the inputs:
  - `nr_override` is 1;
  - `n_val` is {reg6[1:0], reg7};
  - `r_val` is reg8[7:1].
  When `reg8[0]` is 0, all three outputs are 0.
- R9: During and right after reset, `code`, `code_change`, `smooth`, `pin_oe`, `n_val` and `r_val` are 0, and `group` is 2'd2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Supply-stable indication, synchronous to clk |
| strap_pin | input | 4 | Strap levels read from the shared pins (S3,S2,S1,S0) |
| reg0 | input | 8 | Control register 0: software code bits and override bit 3 |
| reg6 | input | 8 | Control register 6: N9:N8 in bits 1:0 |
| reg7 | input | 8 | Control register 7: N7:N0 |
| reg8 | input | 8 | Control register 8: R6:R0 in bits 7:1, N/R override in bit 0 |
| pin_oe | output | 1 | Output enable for the shared pin drivers |
| code | output | 5 | Resolved frequency code |
| group | output | 2 | PLL group of `code` (1, 2 or 3) |
| code_change | output | 1 | One-cycle pulse when `code` changes |
| smooth | output | 1 | 1 when the last change stayed within one group |
| nr_override | output | 1 | Software N/R values are active |
| n_val | output | 10 | Programmed N value |
| r_val | output | 7 | Programmed R value |

## Verification
The hardest situation to reach is a strap value that must be frozen even though the pins move again afterwards. Before the driver-enable edge, only the synchronized copy is visible, and after it the pins are clocks. The bench places the straps before power-good, checks the exact edge on which `pin_oe` rises, and then moves the pins while hardware selection is active. Any leak of the new pin value into `code` therefore shows at the ports. Group transitions are walked as a chain of software codes chosen so that same-group and cross-group steps alternate, covering both values of `smooth` in all three groups.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    localparam int CODE_W = 5;
    localparam int STRAP_W = 4;

    typedef logic [CODE_W-1:0] code_t;

    // PLL group of a frequency code: 1, 2 or 3
    function automatic logic [1:0] group_of(input code_t c);
        logic [1:0] g;
        case (c)
            5'b00001, 5'b00010, 5'b00111, 5'b01101, 5'b10001, 5'b10010,
            5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101, 5'b11110,
            5'b11111: g = 2'd1;
            5'b00000, 5'b00011, 5'b00110, 5'b01010, 5'b10000,
            5'b10101: g = 2'd2;
            default:  g = 2'd3;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
    parameter int SETTLE_CYCLES = 1000,
    parameter int STRAP_W       = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_good,
    input  logic [STRAP_W-1:0] strap_pin,
    output logic               latched,
    output logic [STRAP_W-1:0] strap_val
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    typedef struct packed {
        logic [STRAP_W-1:0] sync1;
        logic [STRAP_W-1:0] sync2;
        logic [CNT_W-1:0]   cnt;
        logic               done;
        logic [STRAP_W-1:0] strap;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = strap_pin;
        st_d.sync2 = st_q.sync1;
        if (!st_q.done) begin
            if (!pwr_good) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == LAST) begin
                st_d.done  = 1'b1;
                st_d.strap = st_q.sync2;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latched   = st_q.done;
    assign strap_val = st_q.strap;

    // R1
    oe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latched |=> latched);

    // R2
    strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latched |=> $stable(strap_val));

endmodule

// File: rtl/code_resolver.sv
module code_resolver
    import fsel_pkg::*;
#(
    parameter int N_W = 10,
    parameter int R_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_val,
    input  logic [7:0]         reg0,
    input  logic [7:0]         reg6,
    input  logic [7:0]         reg7,
    input  logic [7:0]         reg8,
    output code_t              code,
    output logic [1:0]         group,
    output logic               code_change,
    output logic               smooth,
    output logic               nr_override,
    output logic [N_W-1:0]     n_val,
    output logic [R_W-1:0]     r_val
);
    typedef struct packed {
        code_t          code;
        logic           chg;
        logic           smooth;
        logic           ovr;
        logic [N_W-1:0] n;
        logic [R_W-1:0] r;
    } res_state_t;

    res_state_t st_d, st_q;
    code_t      next_code;

    always_comb begin
        if (reg0[3])
            next_code = {reg0[7], reg0[2], reg0[6], reg0[5], reg0[4]};
        else
            next_code = {1'b0, strap_val[3], strap_val[2], strap_val[1], strap_val[0]};

        st_d      = st_q;
        st_d.code = next_code;
        st_d.chg  = (next_code != st_q.code);
        if (next_code != st_q.code)
            st_d.smooth = (group_of(next_code) == group_of(st_q.code));
        st_d.ovr  = reg8[0];
        st_d.n    = reg8[0] ? N_W'({reg6[1:0], reg7}) : '0;
        st_d.r    = reg8[0] ? reg8[R_W:1] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code        = st_q.code;
    assign group       = group_of(st_q.code);
    assign code_change = st_q.chg;
    assign smooth      = st_q.smooth;
    assign nr_override = st_q.ovr;
    assign n_val       = st_q.n;
    assign r_val       = st_q.r;

    // R6
    change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_change |-> (code != $past(code)));

    // R6
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !code_change |-> $stable(code));

    // R7
    smooth_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !code_change |-> $stable(smooth));

    // R8
    nr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nr_override |-> (n_val == '0 && r_val == '0));

endmodule

// File: rtl/freq_sel_ctrl.sv
module freq_sel_ctrl
    import fsel_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic [3:0] strap_pin,
    input  logic [7:0] reg0,
    input  logic [7:0] reg6,
    input  logic [7:0] reg7,
    input  logic [7:0] reg8,
    output logic       pin_oe,
    output logic [4:0] code,
    output logic [1:0] group,
    output logic       code_change,
    output logic       smooth,
    output logic       nr_override,
    output logic [9:0] n_val,
    output logic [6:0] r_val
);
    logic [STRAP_W-1:0] strap_val;

    strap_capture #(
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .STRAP_W       (STRAP_W)
    ) i_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .strap_pin (strap_pin),
        .latched   (pin_oe),
        .strap_val (strap_val)
    );

    code_resolver #(
        .N_W (10),
        .R_W (7)
    ) i_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_val   (strap_val),
        .reg0        (reg0),
        .reg6        (reg6),
        .reg7        (reg7),
        .reg8        (reg8),
        .code        (code),
        .group       (group),
        .code_change (code_change),
        .smooth      (smooth),
        .nr_override (nr_override),
        .n_val       (n_val),
        .r_val       (r_val)
    );

    // R5
    group_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        group != 2'd0);

endmodule

// File: tb/test_freq_sel_ctrl.sv
module test_freq_sel_ctrl;
    localparam int SETTLE = 8;
    localparam int NVEC   = 8;
    // stimulus code and expected group, applied in order
    localparam logic [6:0] VEC [NVEC] = '{
        {5'b00111, 2'd1}, {5'b01101, 2'd1}, {5'b00000, 2'd2}, {5'b10101, 2'd2},
        {5'b11001, 2'd3}, {5'b01000, 2'd3}, {5'b11111, 2'd1}, {5'b10001, 2'd1}
    };

    logic clk = 0, rst_n = 0, pwr_good = 0;
    logic [3:0] strap_pin = 4'b0000;
    logic [7:0] reg0 = 0, reg6 = 0, reg7 = 0, reg8 = 0;
    logic pin_oe, code_change, smooth, nr_override;
    logic [4:0] code;
    logic [1:0] group;
    logic [9:0] n_val;
    logic [6:0] r_val;
    int errors = 0, checks = 0;

    always #5 clk = ~clk;

    freq_sel_ctrl #(.SETTLE_CYCLES(SETTLE)) i_freq_sel_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strap_pin(strap_pin),
        .reg0(reg0), .reg6(reg6), .reg7(reg7), .reg8(reg8), .pin_oe(pin_oe),
        .code(code), .group(group), .code_change(code_change), .smooth(smooth),
        .nr_override(nr_override), .n_val(n_val), .r_val(r_val));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] sw_reg(input logic [4:0] c);
        return {c[4], c[2], c[1], c[0], 1'b1, c[3], 2'b00};
    endfunction

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [1:0] prev_g;
        edges(3);
        // R9 reset state
        chk("R9 oe", pin_oe, 0);
        chk("R9 code", code, 0);
        chk("R9 group", group, 2);
        chk("R9 chg", {code_change, smooth, nr_override}, 0);
        chk("R9 nr", {n_val, r_val}, 0);
        rst_n = 1;
        strap_pin = 4'b0101; // S3=0 S2=1 S1=0 S0=1
        edges(4);
        chk("R1 oe before power-good", pin_oe, 0);
        // R1 restart when power-good drops early
        pwr_good = 1;
        edges(3);
        pwr_good = 0;
        edges(1);
        pwr_good = 1;
        edges(SETTLE - 1);
        chk("R1 oe one edge early", pin_oe, 0);
        edges(1);
        chk("R1 oe at settle", pin_oe, 1);
        edges(1);
        chk("R3 strap code", code, 5'b00101);
        chk("R5 strap group", group, 3);
        // R2 later pin moves are ignored
        strap_pin = 4'b1010;
        edges(6);
        chk("R2 code after pin move", code, 5'b00101);
        chk("R1 oe stays", pin_oe, 1);
        chk("R2 no change pulse", code_change, 0);
        // R4 R5 R6 R7 vector walk
        prev_g = 2'd3;
        for (int i = 0; i < NVEC; i++) begin
            reg0 = sw_reg(VEC[i][6:2]);
            edges(1);
            chk("R4 sw code", code, VEC[i][6:2]);
            chk("R5 group", group, VEC[i][1:0]);
            chk("R6 pulse high", code_change, 1);
            chk("R7 smooth", smooth, (prev_g == VEC[i][1:0]) ? 1 : 0);
            edges(1);
            chk("R6 pulse low", code_change, 0);
            prev_g = VEC[i][1:0];
        end
        // R3 back to hardware selection: frozen straps, not current pins
        reg0 = 8'h00;
        edges(1);
        chk("R3 hw code again", code, 5'b00101);
        chk("R7 cross-group jump", smooth, 0);
        // R8 N/R override
        reg6 = 8'hFE; reg7 = 8'h47; reg8 = 8'b0110_0001;
        edges(1);
        chk("R8 override", nr_override, 1);
        chk("R8 n", n_val, 10'h247);
        chk("R8 r", r_val, 7'h30);
        reg8 = 8'b0110_0000;
        edges(1);
        chk("R8 off", {nr_override, n_val, r_val}, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule